// File: doc/BRIEF.md
# Destination Routing Stage with Failover

This stage sits between a link receiver and the layers above it. Each unit that arrives is 72 bits wide, an 8-bit header followed by a 64-bit payload. The stage reads the destination identifier from the header and uses it to index a small routing table. The table entry says what to do with the unit. It is either handed to the local upper-layer port because it has reached this node, or it is sent on one of several outbound link ports.

Each table entry holds a local-delivery flag, a preferred link and a fallback link. A per-link failure input lets the stage bypass a dead preferred link without waiting for software. If both links in an entry are down, the unit is discarded and counted. A management write port can rewrite any entry while traffic flows. The unit whose lookup coincides with a write still uses the entry as it was before the write. Every port uses a valid/ready handshake, and units leave in the order they arrived.

Top module: `route_stage`

## Requirements
- R1: A unit's header occupies bits [71:64]: the destination ID is bits [71:67] and the message type is bits [66:64]. The payload is bits [63:0]. A delivered unit leaves with all 72 bits unchanged, including the type, which does not affect routing.
- R2: A unit whose table entry has the local flag set is presented on the local port, whatever the link-failure inputs say.
- R3: A unit whose entry has the local flag clear goes to the entry's preferred link when that link's failure input is low.
- R4: When the preferred link's failure input is high and the fallback link's is low, the unit goes to the fallback link.
- R5: When both links of a non-local entry are marked failed, the unit is accepted and no output presents it. The drop counter then rises by exactly one.
- R6: A table write in the same cycle as a unit's acceptance does not affect that unit. Every unit accepted afterwards uses the new entry.
- R7: A presented unit stays valid and unchanged until its port is ready. While a unit is blocked, in_ready is low. With no unit held, in_ready is high.
- R8: At most one output port is valid in any cycle, and units leave in their order of acceptance.
- R9: After reset no output is valid, in_ready is high and the drop counter is zero. Entry d holds the preferred link d mod NUM_LINKS and the fallback link (d+1) mod NUM_LINKS, with the local flag clear.
- R10: The drop counter saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming unit valid |
| in_ready | output | 1 | Stage can accept a unit |
| in_unit | input | UNIT_W | Incoming unit: header in [71:64], payload in [63:0] |
| loc_valid | output | 1 | Unit for this node is valid |
| loc_ready | input | 1 | Upper layer accepts the unit |
| loc_unit | output | UNIT_W | Unit for this node |
| lnk_valid | output | NUM_LINKS | Per-link outbound valid |
| lnk_ready | input | NUM_LINKS | Per-link outbound ready |
| lnk_unit | output | NUM_LINKS*UNIT_W | Outbound unit, one lane per link (lane i at [i*UNIT_W +: UNIT_W]) |
| link_down | input | NUM_LINKS | Per-link failure indication |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | DST_W | Entry to write (destination ID) |
| tbl_primary | input | PORT_W | Preferred link for the written entry |
| tbl_alternate | input | PORT_W | Fallback link for the written entry |
| tbl_local | input | 1 | Local-delivery flag for the written entry |
| drop_count | output | CNT_W | Saturating count of discarded units |

## Verification
The bound checker watches, on every cycle, the rules that the port signals show by themselves. At most one output is valid. A blocked output holds its unit and deasserts in_ready. An empty stage is ready. The drop counter moves only by zero or one and stays at its maximum once there. Which port a unit should reach, and whether failover, dropping and the old-entry rule for a coinciding write choose correctly, depends on table contents. Only the bench's scenarios show that: they compare each delivered unit and its port against a model table, in order.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic [1:0] {
        ROUTE_LOCAL = 2'd0,
        ROUTE_LINK  = 2'd1,
        ROUTE_DROP  = 2'd2
    } route_kind_e;
endpackage

// File: rtl/rt_table.sv
module rt_table #(
    parameter int DST_W     = 5,
    parameter int NUM_LINKS = 4,
    parameter int PORT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DST_W-1:0]  wr_addr,
    input  logic [PORT_W-1:0] wr_primary,
    input  logic [PORT_W-1:0] wr_alternate,
    input  logic              wr_local,
    input  logic [DST_W-1:0]  rd_addr,
    output logic [PORT_W-1:0] rd_primary,
    output logic [PORT_W-1:0] rd_alternate,
    output logic              rd_local
);
    localparam int DEPTH = 1 << DST_W;

    typedef struct packed {
        logic              is_local;
        logic [PORT_W-1:0] primary;
        logic [PORT_W-1:0] alternate;
    } entry_t;

    entry_t ent_d [DEPTH];
    entry_t ent_q [DEPTH];

    // Read sees the registered contents, so a write lands after the current lookup.
    assign rd_primary   = ent_q[rd_addr].primary;
    assign rd_alternate = ent_q[rd_addr].alternate;
    assign rd_local     = ent_q[rd_addr].is_local;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_addr].is_local  = wr_local;
            ent_d[wr_addr].primary   = wr_primary;
            ent_d[wr_addr].alternate = wr_alternate;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i].is_local  <= 1'b0;
                ent_q[i].primary   <= PORT_W'(i % NUM_LINKS);
                ent_q[i].alternate <= PORT_W'((i + 1) % NUM_LINKS);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end
endmodule

// File: rtl/rt_decide.sv
module rt_decide
    import rt_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int PORT_W    = 2
) (
    input  logic                 is_local,
    input  logic [PORT_W-1:0]    primary,
    input  logic [PORT_W-1:0]    alternate,
    input  logic [NUM_LINKS-1:0] link_down,
    output route_kind_e          kind,
    output logic [PORT_W-1:0]    port
);
    always_comb begin
        kind = ROUTE_DROP;
        port = primary;
        if (is_local) begin
            kind = ROUTE_LOCAL;
        end else if (!link_down[primary]) begin
            kind = ROUTE_LINK;
        end else if (!link_down[alternate]) begin
            kind = ROUTE_LINK;
            port = alternate;
        end
    end
endmodule

// File: rtl/rt_slot.sv
module rt_slot #(
    parameter int PORT_W = 2,
    parameter int UNIT_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_local,
    input  logic [PORT_W-1:0] load_port,
    input  logic [UNIT_W-1:0] load_unit,
    input  logic              drain,
    output logic              out_valid,
    output logic              out_local,
    output logic [PORT_W-1:0] out_port,
    output logic [UNIT_W-1:0] out_unit
);
    typedef struct packed {
        logic              valid;
        logic              is_local;
        logic [PORT_W-1:0] port;
        logic [UNIT_W-1:0] unit;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (drain) begin
            st_d.valid = 1'b0;
        end
        if (load) begin
            st_d.valid    = 1'b1;
            st_d.is_local = load_local;
            st_d.port     = load_port;
            st_d.unit     = load_unit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_local = st_q.is_local;
    assign out_port  = st_q.port;
    assign out_unit  = st_q.unit;
endmodule

// File: rtl/route_stage.sv
module route_stage
    import rt_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int DST_W     = 5,
    parameter int TYPE_W    = 3,
    parameter int PAY_W     = 64,
    parameter int CNT_W     = 16,
    localparam int HDR_W    = DST_W + TYPE_W,
    localparam int UNIT_W   = HDR_W + PAY_W,
    localparam int PORT_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [UNIT_W-1:0]           in_unit,
    output logic                        loc_valid,
    input  logic                        loc_ready,
    output logic [UNIT_W-1:0]           loc_unit,
    output logic [NUM_LINKS-1:0]        lnk_valid,
    input  logic [NUM_LINKS-1:0]        lnk_ready,
    output logic [NUM_LINKS*UNIT_W-1:0] lnk_unit,
    input  logic [NUM_LINKS-1:0]        link_down,
    input  logic                        tbl_we,
    input  logic [DST_W-1:0]            tbl_addr,
    input  logic [PORT_W-1:0]           tbl_primary,
    input  logic [PORT_W-1:0]           tbl_alternate,
    input  logic                        tbl_local,
    output logic [CNT_W-1:0]            drop_count
);
    logic [DST_W-1:0]  dest_id;
    logic [PORT_W-1:0] ent_primary, ent_alternate, route_port;
    logic              ent_local;
    route_kind_e       route_kind;

    logic              slot_valid, slot_local, slot_fire;
    logic [PORT_W-1:0] slot_port;
    logic [UNIT_W-1:0] slot_unit;
    logic              accept, load, drop;

    typedef struct packed {
        logic [CNT_W-1:0] drops;
    } cnt_t;
    cnt_t cnt_d, cnt_q;

    assign dest_id = in_unit[UNIT_W-1 -: DST_W];

    rt_table #(.DST_W(DST_W), .NUM_LINKS(NUM_LINKS), .PORT_W(PORT_W)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (tbl_we),
        .wr_addr      (tbl_addr),
        .wr_primary   (tbl_primary),
        .wr_alternate (tbl_alternate),
        .wr_local     (tbl_local),
        .rd_addr      (dest_id),
        .rd_primary   (ent_primary),
        .rd_alternate (ent_alternate),
        .rd_local     (ent_local)
    );

    rt_decide #(.NUM_LINKS(NUM_LINKS), .PORT_W(PORT_W)) u_decide (
        .is_local  (ent_local),
        .primary   (ent_primary),
        .alternate (ent_alternate),
        .link_down (link_down),
        .kind      (route_kind),
        .port      (route_port)
    );

    assign slot_fire = slot_valid && (slot_local ? loc_ready : lnk_ready[slot_port]);
    assign in_ready  = !slot_valid || slot_fire;
    assign accept    = in_valid && in_ready;
    assign load      = accept && (route_kind != ROUTE_DROP);
    assign drop      = accept && (route_kind == ROUTE_DROP);

    rt_slot #(.PORT_W(PORT_W), .UNIT_W(UNIT_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_local (route_kind == ROUTE_LOCAL),
        .load_port  (route_port),
        .load_unit  (in_unit),
        .drain      (slot_fire),
        .out_valid  (slot_valid),
        .out_local  (slot_local),
        .out_port   (slot_port),
        .out_unit   (slot_unit)
    );

    assign loc_valid = slot_valid && slot_local;
    assign loc_unit  = slot_unit;

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_lane
        assign lnk_valid[g]                   = slot_valid && !slot_local && (slot_port == PORT_W'(g));
        assign lnk_unit[g*UNIT_W +: UNIT_W]   = slot_unit;
    end

    always_comb begin
        cnt_d = cnt_q;
        if (drop && !(&cnt_q.drops)) begin
            cnt_d.drops = cnt_q.drops + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign drop_count = cnt_q.drops;
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
    parameter int NUM_LINKS = 4,
    parameter int CNT_W     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_ready,
    input logic                 loc_valid,
    input logic                 loc_ready,
    input logic [71:0]          loc_unit,
    input logic [NUM_LINKS-1:0] lnk_valid,
    input logic [NUM_LINKS-1:0] lnk_ready,
    input logic [71:0]          lane0_unit,
    input logic [CNT_W-1:0]     drop_count
);
    logic lnk_stall;
    logic any_valid;
    assign lnk_stall = |(lnk_valid & ~lnk_ready);
    assign any_valid = loc_valid || (|lnk_valid);

    p_single_output_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_valid, lnk_valid}));

    p_local_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && !loc_ready) |=> (loc_valid && $stable(loc_unit)));

    p_link_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_stall |=> ($stable(lnk_valid) && $stable(lane0_unit)));

    p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((loc_valid && !loc_ready) || lnk_stall) |-> !in_ready);

    p_empty_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !any_valid |-> in_ready);

    p_drop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((drop_count == $past(drop_count)) ||
                  (drop_count == $past(drop_count) + 1'b1)));

    p_drop_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&drop_count) |=> (&drop_count));
endmodule

bind route_stage rt_checker #(.NUM_LINKS(NUM_LINKS), .CNT_W(CNT_W)) u_rt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .loc_valid  (loc_valid),
    .loc_ready  (loc_ready),
    .loc_unit   (loc_unit),
    .lnk_valid  (lnk_valid),
    .lnk_ready  (lnk_ready),
    .lane0_unit (lnk_unit[71:0]),
    .drop_count (drop_count)
);

// File: tb/route_stage_test.sv
module route_stage_test;
    localparam int NL = 4;
    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [71:0]     in_unit = '0;
    logic            loc_valid;
    logic            loc_ready = 1'b1;
    logic [71:0]     loc_unit;
    logic [NL-1:0]   lnk_valid;
    logic [NL-1:0]   lnk_ready = '1;
    logic [NL*72-1:0] lnk_unit;
    logic [NL-1:0]   link_down = '0;
    logic            tbl_we = 1'b0;
    logic [4:0]      tbl_addr = '0;
    logic [1:0]      tbl_primary = '0;
    logic [1:0]      tbl_alternate = '0;
    logic            tbl_local = 1'b0;
    logic [CW-1:0]   drop_count;

    route_stage #(.NUM_LINKS(NL), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_unit(in_unit),
        .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_unit(loc_unit),
        .lnk_valid(lnk_valid), .lnk_ready(lnk_ready), .lnk_unit(lnk_unit),
        .link_down(link_down), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_primary(tbl_primary), .tbl_alternate(tbl_alternate), .tbl_local(tbl_local),
        .drop_count(drop_count)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          port;
        logic [71:0] unit;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    int          drops = 0;
    int          bp_mode = 0;
    int          cyc = 0;
    bit          finished = 0;
    logic [1:0]  m_prim [32];
    logic [1:0]  m_alt  [32];
    bit          m_loc  [32];

    task automatic check(bit ok, string req, logic [71:0] act, logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [71:0] mk(logic [4:0] d, logic [2:0] t, logic [63:0] p);
        return {d, t, p};
    endfunction

    // Model of the routing decision from the requirements, using the current model table.
    task automatic predict(logic [71:0] u);
        int d;
        exp_t e;
        d = int'(u[71:67]);
        e.unit = u;
        if (m_loc[d]) begin
            e.port = -1;
            exp_q.push_back(e);
        end else if (!link_down[m_prim[d]]) begin
            e.port = int'(m_prim[d]);
            exp_q.push_back(e);
        end else if (!link_down[m_alt[d]]) begin
            e.port = int'(m_alt[d]);
            exp_q.push_back(e);
        end else begin
            drops++;
        end
    endtask

    task automatic send(logic [71:0] u, bit wr = 0, logic [4:0] wa = '0,
                        logic [1:0] wp = '0, logic [1:0] walt = '0, bit wl = 0);
        bit done = 0;
        bit wpend = wr;
        @(negedge clk);
        in_valid = 1'b1;
        in_unit = u;
        tbl_we = wpend;
        tbl_addr = wa;
        tbl_primary = wp;
        tbl_alternate = walt;
        tbl_local = wl;
        while (!done) begin
            #1;
            if (in_ready) begin
                predict(u);
                done = 1;
            end
            @(posedge clk);
            if (wpend) begin
                m_prim[wa] = wp;
                m_alt[wa] = walt;
                m_loc[wa] = wl;
                wpend = 0;
            end
            @(negedge clk);
            tbl_we = 1'b0;
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_drops(string req);
        int e;
        repeat (2) @(negedge clk);
        e = (drops > 15) ? 15 : drops;
        check(drop_count == CW'(e), req, 72'(drop_count), 72'(e));
    endtask

    // Monitor: sets output readiness each cycle and compares each handshake in order.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            loc_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? cyc[0] : 1'b0;
            lnk_ready = (bp_mode == 0) ? '1 : (bp_mode == 1) ? {NL{~cyc[0]}} : '0;
            #2;
            if (rst_n) begin
                if ($countones({loc_valid, lnk_valid}) > 1)
                    check(1'b0, "R8 single output", 72'({loc_valid, lnk_valid}), 72'(0));
                if (loc_valid && loc_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8 unexpected local unit", loc_unit, 72'(0));
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(e.port == -1 && loc_unit == e.unit, "R1 R2 R8 local unit",
                              loc_unit, e.unit);
                    end
                end
                for (int i = 0; i < NL; i++) begin
                    if (lnk_valid[i] && lnk_ready[i]) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R8 unexpected link unit", lnk_unit[i*72 +: 72], 72'(0));
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            check(e.port == i && lnk_unit[i*72 +: 72] == e.unit,
                                  "R1 R3 R4 R8 link unit",
                                  {lnk_unit[i*72 +: 68], 4'(i)}, {e.unit[67:0], 4'(e.port)});
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 72'(cyc), 72'(0));
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_prim[i] = 2'(i % NL);
            m_alt[i]  = 2'((i + 1) % NL);
            m_loc[i]  = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        check(!loc_valid && lnk_valid == '0, "R9 no output valid", 72'({loc_valid, lnk_valid}), 72'(0));
        check(in_ready == 1'b1, "R9 in_ready", 72'(in_ready), 72'(1));
        check(drop_count == '0, "R9 drop count", 72'(drop_count), 72'(0));

        // R9 R3 R1: default table, types vary, all links up
        for (int d = 0; d < 8; d++) begin
            send(mk(5'(d), 3'(7 - d), 64'h1111_0000_0000_0000 + 64'(d * 3)));
        end
        drain();

        // R2: local entry wins even with its links down
        send(mk(5'd20, 3'd0, 64'h0), 1, 5'd3, 2'd2, 2'd3, 1'b1);
        link_down = 4'b1100;
        send(mk(5'd3, 3'd5, 64'hDEAD_BEEF_0000_0003));
        drain();
        link_down = '0;

        // R4: failover to alternate
        send(mk(5'd21, 3'd1, 64'h5), 1, 5'd9, 2'd1, 2'd2, 1'b0);
        drain();
        link_down = 4'b0010;
        send(mk(5'd9, 3'd2, 64'hAAAA_5555_0000_0009));
        drain();

        // R5: both down -> drop
        link_down = 4'b0011;
        send(mk(5'd4, 3'd4, 64'hBAD0));
        drain();
        check_drops("R5 drop counted");
        check(exp_q.size() == 0, "R5 nothing delivered", 72'(exp_q.size()), 72'(0));
        link_down = '0;

        // R6: write coinciding with lookup uses old entry, next unit uses new
        send(mk(5'd10, 3'd3, 64'h0A0A_0001), 1, 5'd10, 2'd3, 2'd0, 1'b1);
        send(mk(5'd10, 3'd3, 64'h0A0A_0002));
        drain();

        // R7 R8: alternating backpressure, mixed ports, order kept
        bp_mode = 1;
        for (int k = 0; k < 12; k++) begin
            send(mk(5'(k % 12), 3'(k), 64'hC0DE_0000_0000_0000 + 64'(k)));
        end
        drain();

        // R7: fully blocked output holds the unit and stalls input
        bp_mode = 2;
        send(mk(5'd0, 3'd6, 64'h7777_0000_0000_0000));
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            #1;
            check(in_ready == 1'b0, "R7 in_ready low when blocked", 72'(in_ready), 72'(0));
            check(lnk_valid == 4'b0001 && lnk_unit[71:0] == mk(5'd0, 3'd6, 64'h7777_0000_0000_0000),
                  "R7 unit held", lnk_unit[71:0], mk(5'd0, 3'd6, 64'h7777_0000_0000_0000));
        end
        bp_mode = 0;
        drain();

        // R10: counter saturation
        link_down = 4'b1111;
        for (int k = 0; k < 16; k++) begin
            send(mk(5'd5, 3'd0, 64'(k)));
        end
        check_drops("R10 saturation");
        link_down = '0;
        send(mk(5'd6, 3'd1, 64'hF1F1));
        drain();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule